// File: doc/BRIEF.md
# Secure Memory Transaction Filter

This block sits in the path from one upstream master to one downstream memory. It decides, per transaction, whether the request may continue. Memory is split into equal power-of-two blocks. Each block has one attribute bit in a lookup table that lives in a separate register file. The bit says which security world may touch that block. A request from the allowed world goes downstream unchanged. A request from the other world is turned back on a response channel. It gets either a bus error or a silent completion, depending on a control input.

The first rejected request is recorded in two capture values: the address, and a word with the master ID and the security flags. A one-cycle pulse then asks the register file to set its interrupt status. Later rejections are still turned back, but they overwrite nothing until software has cleared that status. The table is read through a combinational word port: the block drives a word index and samples the returned word in the same cycle.

The request, forward and response interfaces all use valid/ready:
- A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- An accepted request sits in a one-entry stage. From there it leaves on exactly one output: the forward channel if it passes, or the response channel if it is blocked.
- That output's valid stays high, with stable payload, until its ready is seen.
- `req_ready` is low while the stage is full and its output is stalled.

Top module: `sec_txn_filter`

## Requirements
- R1: After reset, `req_ready` is 1; `fwd_valid`, `rsp_valid` and `irq_set` are 0; `cap_addr` and `cap_info` are 0.
- R2: For address A with block size S = 2^k:
  - the block number is A >> k;
  - the table word index `tbl_idx` is A >> (k+5);
  - the bit used is bit A[k+4:k] of `tbl_word`.
- R3: A table bit of 1 passes only non-secure requests (`req_nonsec`=1). A table bit of 0 passes only secure requests.
- R4: A request with `req_unspec`=1 is treated as secure, whatever `req_nonsec` says.
- R5: A passing request shows up on the forward channel in the cycle after acceptance. Its address, write data, write flag, non-secure flag, unspecified flag and master ID are unchanged, and no response is raised for it.
- R6: A blocked request is never forwarded. It raises `rsp_valid` in the cycle after acceptance, with `rsp_err` equal to `err_resp_en` as sampled at acceptance. With `rsp_err`=0, a blocked read completes with zero data and a blocked write is dropped.
- R7: A blocked request accepted while `irq_stat` is 0 and `irq_set` is 0 does three things:
  - `cap_addr` takes its address;
  - `cap_info` takes the master ID in bits 15:0, the effective non-secure flag (0 when unspecified) in bit 16, the table bit in bit 17, and zeros above;
  - `irq_set` pulses high for exactly the one cycle after acceptance.
- R8: A blocked request accepted while `irq_stat` is 1, or while `irq_set` is high, leaves `cap_addr` and `cap_info` unchanged and raises no `irq_set`.
- R9: While a stage output is valid and its ready is low, that valid stays high, its payload is stable and `req_ready` is 0.
- R10: The pass decision uses the value of `tbl_word` in the cycle of acceptance. Later table changes do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_resp_en | input | 1 | 1: blocked requests get a bus error |
| irq_stat | input | 1 | Interrupt status held in the register file |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1: write, 0: read |
| req_nonsec | input | 1 | 1: non-secure request |
| req_unspec | input | 1 | 1: attributes unspecified (treated secure) |
| req_master | input | 16 | Master ID |
| tbl_idx | output | IDX_W | Table word index for the request address |
| tbl_word | input | 32 | Table word returned for `tbl_idx` in the same cycle |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Downstream ready |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_nonsec | output | 1 | Forwarded non-secure flag |
| fwd_unspec | output | 1 | Forwarded unspecified flag |
| fwd_master | output | 16 | Forwarded master ID |
| rsp_valid | output | 1 | Blocked-response valid |
| rsp_ready | input | 1 | Upstream takes the blocked response |
| rsp_err | output | 1 | Blocked response carries a bus error |
| irq_set | output | 1 | One-cycle request to set the interrupt status |
| cap_addr | output | ADDR_W | Captured address of the first blocked request |
| cap_info | output | 32 | Captured master ID and flags |

## Verification
The bench targets the mapping from address to table word and bit. It uses a single set bit at block 33 and probes blocks 32 and 34, so an off-by-one in the shift, or the wrong bit order, turns a pass into a block on a neighbour.

It also covers the following cases, each of which a faulty design would get visibly wrong:
- An unspecified request aimed at a non-secure block. A design that trusted the raw non-secure flag would let it through.
- Two rejections on consecutive cycles, before the register file shows the status. A design that gated only on `irq_stat` would overwrite the first capture.
- A table change while a request waits behind a stalled forward channel. A design that sampled the table late would decide with the wrong bit.

// File: rtl/sec_filt_pkg.sv
package sec_filt_pkg;

  localparam int MID_W       = 16;
  localparam int INFO_NS_BIT = 16;
  localparam int INFO_TB_BIT = 17;

  typedef struct packed {
    logic             write;
    logic             nonsec;
    logic             unspec;
    logic [MID_W-1:0] mid;
  } sec_attr_t;

  // Unspecified attributes are handled as secure.
  function automatic logic eff_nonsec(sec_attr_t a);
    return a.nonsec & ~a.unspec;
  endfunction

  function automatic logic [31:0] pack_info(sec_attr_t a, logic tbit);
    logic [31:0] w;
    w = '0;
    w[MID_W-1:0]  = a.mid;
    w[INFO_NS_BIT] = eff_nonsec(a);
    w[INFO_TB_BIT] = tbit;
    return w;
  endfunction

endpackage

// File: rtl/sec_filt_lookup.sv
module sec_filt_lookup #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       tbl_word,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_bit
);
  localparam int WORD_SHIFT = BLK_SHIFT + 5;

  logic [ADDR_W-1:0] word_num;
  logic [4:0]        bit_sel;

  always_comb begin
    word_num = addr >> WORD_SHIFT;
    tbl_idx  = word_num[IDX_W-1:0];
    bit_sel  = addr[BLK_SHIFT +: 5];
    tbl_bit  = tbl_word[bit_sel];
  end

  initial begin
    AST_SHIFT_FITS: assert (ADDR_W >= WORD_SHIFT) else $error("address too narrow"); // R2
  end
endmodule

// File: rtl/sec_filt_stage.sv
module sec_filt_stage
  import sec_filt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  sec_attr_t         in_attr,
  input  logic              in_pass,
  input  logic              in_err,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output sec_attr_t         fwd_attr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err
);
  logic              s_vld;
  logic              s_pass;
  logic              s_err;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  sec_attr_t         s_attr;
  logic              drain;

  always_comb begin
    drain    = s_vld & (s_pass ? fwd_ready : rsp_ready);
    in_ready = ~s_vld | drain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld   <= 1'b0;
      s_pass  <= 1'b0;
      s_err   <= 1'b0;
      s_addr  <= '0;
      s_wdata <= '0;
      s_attr  <= '0;
    end else if (in_ready) begin
      s_vld <= in_valid;
      if (in_valid) begin
        s_pass  <= in_pass;
        s_err   <= in_err;
        s_addr  <= in_addr;
        s_wdata <= in_wdata;
        s_attr  <= in_attr;
      end
    end
  end

  always_comb begin
    fwd_valid = s_vld & s_pass;
    rsp_valid = s_vld & ~s_pass;
    rsp_err   = s_err;
    fwd_addr  = s_addr;
    fwd_wdata = s_wdata;
    fwd_attr  = s_attr;
  end

  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_wdata)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err)); // R9
  AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, rsp_valid})); // R6
endmodule

// File: rtl/sec_filt_capture.sv
module sec_filt_capture
  import sec_filt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_accept,
  input  logic [ADDR_W-1:0] blk_addr,
  input  sec_attr_t         blk_attr,
  input  logic              blk_tbit,
  input  logic              irq_stat,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [31:0]       cap_info,
  output logic              irq_set
);
  logic take;

  // The pulse of the previous capture also gates: the status is not yet visible.
  assign take = blk_accept & ~irq_stat & ~irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_info <= '0;
      irq_set  <= 1'b0;
    end else begin
      irq_set <= take;
      if (take) begin
        cap_addr <= blk_addr;
        cap_info <= pack_info(blk_attr, blk_tbit);
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !irq_set); // R7
  AST_HOLD_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat |=> $stable(cap_addr) && $stable(cap_info) && !irq_set); // R8
endmodule

// File: rtl/sec_txn_filter.sv
module sec_txn_filter
  import sec_filt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BLK_SIZE  = 256,
  parameter int MEM_BYTES = 65536,
  localparam int BLK_SHIFT = $clog2(BLK_SIZE),
  localparam int NUM_BLKS  = MEM_BYTES / BLK_SIZE,
  localparam int NUM_WORDS = (NUM_BLKS + 31) / 32,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_resp_en,
  input  logic              irq_stat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_nonsec,
  input  logic              req_unspec,
  input  logic [15:0]       req_master,
  output logic [IDX_W-1:0]  tbl_idx,
  input  logic [31:0]       tbl_word,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              fwd_write,
  output logic              fwd_nonsec,
  output logic              fwd_unspec,
  output logic [15:0]       fwd_master,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic              irq_set,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [31:0]       cap_info
);
  sec_attr_t req_attr;
  sec_attr_t out_attr;
  logic      tbit;
  logic      pass;
  logic      accept;

  always_comb begin
    req_attr.write  = req_write;
    req_attr.nonsec = req_nonsec;
    req_attr.unspec = req_unspec;
    req_attr.mid    = req_master;
  end

  sec_filt_lookup #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .IDX_W(IDX_W)
  ) u_lookup (
    .addr(req_addr), .tbl_word(tbl_word), .tbl_idx(tbl_idx), .tbl_bit(tbit)
  );

  // Bit 1 admits only the non-secure world, bit 0 only the secure world.
  assign pass   = (tbit == eff_nonsec(req_attr));
  assign accept = req_valid & req_ready;

  sec_filt_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_attr(req_attr),
    .in_pass(pass), .in_err(err_resp_en),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .fwd_attr(out_attr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err)
  );

  always_comb begin
    fwd_write  = out_attr.write;
    fwd_nonsec = out_attr.nonsec;
    fwd_unspec = out_attr.unspec;
    fwd_master = out_attr.mid;
  end

  sec_filt_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .blk_accept(accept & ~pass), .blk_addr(req_addr), .blk_attr(req_attr),
    .blk_tbit(tbit), .irq_stat(irq_stat),
    .cap_addr(cap_addr), .cap_info(cap_info), .irq_set(irq_set)
  );

  AST_STALL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |-> !req_ready); // R9
  AST_PULSE_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> rsp_valid && !fwd_valid); // R7
  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> fwd_valid || rsp_valid); // R5
endmodule

// File: tb/sec_txn_filter_tb_top.sv
`timescale 1ns/1ps
module sec_txn_filter_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_resp_en = 1'b0;
  logic irq_stat = 1'b0;
  logic clr_stat = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_write = 1'b0, req_nonsec = 1'b0, req_unspec = 1'b0;
  logic [15:0] req_master = '0;
  logic [2:0] tbl_idx;
  logic [31:0] tbl_word;
  logic [31:0] tbl [8];
  logic fwd_valid, fwd_ready = 1'b1;
  logic [AW-1:0] fwd_addr;
  logic [DW-1:0] fwd_wdata;
  logic fwd_write, fwd_nonsec, fwd_unspec;
  logic [15:0] fwd_master;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic irq_set;
  logic [AW-1:0] cap_addr;
  logic [31:0] cap_info;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign tbl_word = tbl[tbl_idx];

  // Register-file model of the interrupt status.
  always_ff @(posedge clk) begin
    if (irq_set) irq_stat <= 1'b1;
    else if (clr_stat) irq_stat <= 1'b0;
  end

  sec_txn_filter dut_i (
    .clk(clk), .rst_n(rst_n), .err_resp_en(err_resp_en), .irq_stat(irq_stat),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_nonsec(req_nonsec),
    .req_unspec(req_unspec), .req_master(req_master),
    .tbl_idx(tbl_idx), .tbl_word(tbl_word),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .fwd_write(fwd_write), .fwd_nonsec(fwd_nonsec),
    .fwd_unspec(fwd_unspec), .fwd_master(fwd_master),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .irq_set(irq_set), .cap_addr(cap_addr), .cap_info(cap_info)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected decision, from R2/R3/R4.
  function automatic logic exp_pass(logic [31:0] a, logic ns, logic un);
    logic [31:0] blk;
    blk = a >> 8;
    return tbl[blk >> 5][blk[4:0]] == (ns & ~un);
  endfunction

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic send(input logic [31:0] a, input logic w, input logic ns,
                      input logic un, input logic [15:0] m);
    req_addr = a; req_write = w; req_nonsec = ns; req_unspec = un;
    req_master = m; req_wdata = a ^ 32'h5A5A_0000; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_stat();
    @(negedge clk);
    clr_stat = 1'b1;
    @(negedge clk);
    clr_stat = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_ready", {31'b0, req_ready}, 1);
    chk("R1 fwd_valid", {31'b0, fwd_valid}, 0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R1 irq_set", {31'b0, irq_set}, 0);
    chk("R1 cap_addr", cap_addr, 0);
    chk("R1 cap_info", cap_info, 0);
  endtask

  task automatic t_secure_pass();
    send(32'h0000_0124, 1'b1, 1'b0, 1'b0, 16'h00A1);
    chk("R3 secure to bit0 passes", {31'b0, fwd_valid}, {31'b0, exp_pass(32'h124, 0, 0)});
    chk("R5 fwd_addr", fwd_addr, 32'h0000_0124);
    chk("R5 fwd_wdata", fwd_wdata, 32'h0000_0124 ^ 32'h5A5A_0000);
    chk("R5 fwd_write/master", {15'b0, fwd_write, fwd_master}, {15'b0, 1'b1, 16'h00A1});
    chk("R5 no response", {31'b0, rsp_valid}, 0);
    @(negedge clk);
    chk("R5 drained", {31'b0, fwd_valid}, 0);
  endtask

  task automatic t_ns_block();
    err_resp_en = 1'b0;
    send(32'h0000_0300, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    chk("R6 blocked rsp_valid", {31'b0, rsp_valid}, 1);
    chk("R6 rsp_err off", {31'b0, rsp_err}, 0);
    chk("R6 not forwarded", {31'b0, fwd_valid}, 0);
    chk("R7 cap_addr", cap_addr, 32'h0000_0300);
    chk("R7 cap_info", cap_info, 32'h0001_BEEF);
    chk("R7 irq_set pulse", {31'b0, irq_set}, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, irq_set}, 0);
  endtask

  task automatic t_masked();
    err_resp_en = 1'b1;
    send(32'h0000_0500, 1'b1, 1'b1, 1'b0, 16'h1111);
    chk("R6 rsp_err on", {31'b0, rsp_err}, 1);
    chk("R8 cap_addr kept", cap_addr, 32'h0000_0300);
    chk("R8 cap_info kept", cap_info, 32'h0001_BEEF);
    chk("R8 no pulse", {31'b0, irq_set}, 0);
    clear_stat();
  endtask

  task automatic t_map();
    tbl[1] = 32'h0000_0002;  // block 33 only
    send(32'h0000_2100, 1'b0, 1'b1, 1'b0, 16'h0002);
    chk("R2 block33 ns passes", {31'b0, fwd_valid}, 1);
    send(32'h0000_2000, 1'b0, 1'b1, 1'b0, 16'h0003);
    chk("R2 block32 ns blocked", {31'b0, rsp_valid}, 1);
    chk("R7 info tbit0 ns1", cap_info, 32'h0001_0003);
    clear_stat();
    send(32'h0000_21FF, 1'b0, 1'b0, 1'b0, 16'h0004);
    chk("R3 secure to bit1 blocked", {31'b0, rsp_valid}, 1);
    chk("R7 cap_addr block33", cap_addr, 32'h0000_21FF);
    chk("R7 info tbit1 ns0", cap_info, 32'h0002_0004);
    clear_stat();
    send(32'h0000_2200, 1'b0, 1'b1, 1'b0, 16'h0005);
    chk("R2 block34 ns blocked", {31'b0, rsp_valid}, 1);
    clear_stat();
  endtask

  task automatic t_unspec();
    send(32'h0000_0040, 1'b0, 1'b1, 1'b1, 16'h0006);
    chk("R4 unspec to bit0 passes", {31'b0, fwd_valid}, 1);
    chk("R5 fwd_unspec kept", {30'b0, fwd_nonsec, fwd_unspec}, 32'h3);
    send(32'h0000_2100, 1'b0, 1'b1, 1'b1, 16'h0007);
    chk("R4 unspec to bit1 blocked", {31'b0, rsp_valid}, 1);
    chk("R4 info ns bit 0", cap_info, 32'h0002_0007);
    clear_stat();
  endtask

  task automatic t_backpressure();
    fwd_ready = 1'b0;
    send(32'h0000_0010, 1'b1, 1'b0, 1'b0, 16'h0008);
    chk("R9 held valid", {31'b0, fwd_valid}, 1);
    // Second request (ns to a secure block) waits behind the stall.
    req_addr = 32'h0000_0020; req_nonsec = 1'b1; req_unspec = 1'b0;
    req_write = 1'b0; req_master = 16'h0009; req_valid = 1'b1;
    @(negedge clk);
    chk("R9 still valid", {31'b0, fwd_valid}, 1);
    chk("R9 addr stable", fwd_addr, 32'h0000_0010);
    chk("R9 req_ready low", {31'b0, req_ready}, 0);
    tbl[0] = 32'hFFFF_FFFF;  // changes before acceptance
    fwd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 table at acceptance", {31'b0, fwd_valid}, 1);
    chk("R10 second addr", fwd_addr, 32'h0000_0020);
    tbl[0] = 32'h0;  // after acceptance: must not change routing
    @(negedge clk);
    chk("R10 drained", {31'b0, fwd_valid | rsp_valid}, 0);
  endtask

  task automatic t_back_to_back();
    err_resp_en = 1'b0;
    req_addr = 32'h0000_0600; req_nonsec = 1'b1; req_unspec = 1'b0;
    req_write = 1'b0; req_master = 16'h00C1; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h0000_0700; req_master = 16'h00C2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second rejected", {31'b0, rsp_valid}, 1);
    chk("R8 first capture kept", cap_addr, 32'h0000_0600);
    chk("R8 first info kept", cap_info, 32'h0001_00C1);
    chk("R8 no second pulse", {31'b0, irq_set}, 0);
    clear_stat();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) tbl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_secure_pass();
    t_ns_block();
    t_masked();
    t_map();
    t_unspec();
    t_backpressure();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule